// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Register

This block keeps the one-byte status word of a serial NOR flash slave and decides, cycle by cycle, whether the array may be changed. A front end that shifts and decodes serial commands sends it one-cycle strobes. These cover setting and clearing the write-enable latch, arming a status write, the status write itself with its data byte, any other command, and the completion events of program and erase operations. The block also receives the external active-low write-protect pin, the busy and auto-increment-mode flags of the array sequencer, and the 24-bit target address of the pending operation.

The block returns three things. The first is the status byte that the front end shifts out on a status read. The second is a write permit for the presented address, based on the latch and the top-down protected region. The third is a permit for erasing the whole chip. Array timing, serial shifting and the storage itself live elsewhere.

Top module: `flash_status_reg`

## Requirements
- R1: The status byte carries, from bit 0 up: busy flag (mirrors `busyIn`), write-enable latch, protect bit 0, protect bit 1, two reserved bits that always read 0, auto-increment mode (mirrors `aaiIn`), and the protect-lock bit in bit 7.
- R2: After reset the latch is 0, both protect bits are 1 and the lock bit is 0, so with `busyIn`=`aaiIn`=0 the status byte reads 0x0C and neither permit is asserted.
- R3: `cmdWren` sets the write-enable latch one cycle later. `cmdWrdi` clears it one cycle later.
- R4: A completion strobe clears the latch one cycle later. The completion strobes are byte program, sector erase, block erase, chip erase, and auto-increment reaching the top address. A completion or `cmdWrdi` in the same cycle as `cmdWren` wins.
- R5: A status write is considered only if the command strobe just before it was `cmdEwsr`. Any other command strobe (`cmdWren`, `cmdWrdi`, `cmdWrsr`, `cmdOther`) cancels the armed state, and idle cycles keep it.
- R6: An armed status write is refused when `wpN`=0 and the lock bit is 1, and accepted otherwise. An accepted write loads bit 7 and bits 3:2 of `wrsrData` one cycle later. Busy, latch and auto-increment mode are never written by it.
- R7: With the array quarter taken from address bits 17:16, protect value 00 guards nothing, 01 guards quarter 3, 10 guards quarters 2 and 3, and 11 guards all quarters. Address bits 23:18 and 15:0 do not matter.
- R8: `writePermit` is 1 exactly when the latch is 1 and the presented address is not guarded.
- R9: `chipErasePermit` is 1 exactly when the latch is 1 and both protect bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrdi | input | 1 | Write-disable command strobe |
| cmdEwsr | input | 1 | Arm-status-write command strobe |
| cmdWrsr | input | 1 | Status-write command strobe |
| wrsrData | input | 8 | Data byte of the status write |
| cmdOther | input | 1 | Strobe for any other decoded command |
| byteProgDone | input | 1 | Byte program finished |
| sectorEraseDone | input | 1 | Sector erase finished |
| blockEraseDone | input | 1 | Block erase finished |
| chipEraseDone | input | 1 | Chip erase finished |
| aaiTopReached | input | 1 | Auto-increment programming hit the top address |
| wpN | input | 1 | Write-protect pin, active low |
| busyIn | input | 1 | Array operation in progress |
| aaiIn | input | 1 | Auto-increment programming mode active |
| addr | input | 24 | Target address of the pending operation |
| statusByte | output | 8 | Status word for a status read |
| writePermit | output | 1 | Program or erase allowed at `addr` |
| chipErasePermit | output | 1 | Whole-chip erase allowed |

## Verification
The hardest state to reach is a refused status write. It needs the lock bit already at 1, which in turn needs an earlier accepted write with the pin high. It also needs the pin dropped and the write properly armed, because otherwise the refusal comes from the missing arm and not from the lock. The bench first builds every starting lock value with the pin high. It then lowers or keeps the pin, arms, and writes a set of data patterns. The cancel paths are driven the same way: an arm followed by an unrelated command, and a second write after a consumed arm.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStatus;
  } statusStrobes_t;

  localparam int STATUS_W = 8;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BP0  = 2;
  localparam int BIT_BP1  = 3;
  localparam int BIT_AAI  = 6;
  localparam int BIT_LOCK = 7;
endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdWren,
  input  logic           cmdWrdi,
  input  logic           cmdEwsr,
  input  logic           cmdWrsr,
  input  logic           cmdOther,
  input  logic           byteProgDone,
  input  logic           sectorEraseDone,
  input  logic           blockEraseDone,
  input  logic           chipEraseDone,
  input  logic           aaiTopReached,
  input  logic           wpN,
  input  logic           lockNow,
  output statusStrobes_t strobes
);
  logic armed;
  logic anyCmd;
  logic anyDone;

  assign anyCmd  = cmdWren | cmdWrdi | cmdEwsr | cmdWrsr | cmdOther;
  assign anyDone = byteProgDone | sectorEraseDone | blockEraseDone |
                   chipEraseDone | aaiTopReached;

  // Arm flag: set by the arm command, dropped by any other command.
  always_ff @(posedge clk) begin
    if (!rstN)        armed <= 1'b0;
    else if (cmdEwsr) armed <= 1'b1;
    else if (anyCmd)  armed <= 1'b0;
  end

  always_comb begin
    strobes.setWel     = cmdWren;
    strobes.clrWel     = cmdWrdi | anyDone;
    strobes.loadStatus = cmdWrsr & armed & (wpN | ~lockNow);
  end
endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  statusStrobes_t      strobes,
  input  logic [STATUS_W-1:0] wrData,
  input  logic                busyIn,
  input  logic                aaiIn,
  input  logic [1:0]          quarter,
  output logic [STATUS_W-1:0] statusByte,
  output logic                lockNow,
  output logic                writePermit,
  output logic                chipErasePermit
);
  logic       wel;
  logic       lock;
  logic [1:0] bp;
  logic       guarded;

  always_ff @(posedge clk) begin
    if (!rstN)                wel <= 1'b0;
    else if (strobes.clrWel)  wel <= 1'b0;
    else if (strobes.setWel)  wel <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lock <= 1'b0;
      bp   <= 2'b11;
    end else if (strobes.loadStatus) begin
      lock <= wrData[BIT_LOCK];
      bp   <= {wrData[BIT_BP1], wrData[BIT_BP0]};
    end
  end

  // Guarded region grows downward from the top quarter.
  always_comb begin
    unique case (bp)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = (quarter == 2'b11);
      2'b10:   guarded = quarter[1];
      default: guarded = 1'b1;
    endcase
  end

  always_comb begin
    statusByte           = '0;
    statusByte[BIT_BUSY] = busyIn;
    statusByte[BIT_WEL]  = wel;
    statusByte[BIT_BP0]  = bp[0];
    statusByte[BIT_BP1]  = bp[1];
    statusByte[BIT_AAI]  = aaiIn;
    statusByte[BIT_LOCK] = lock;
  end

  assign lockNow         = lock;
  assign writePermit     = wel & ~guarded;
  assign chipErasePermit = wel & (bp == 2'b00);
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_status_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdEwsr,
  input  logic              cmdWrsr,
  input  logic [7:0]        wrsrData,
  input  logic              cmdOther,
  input  logic              byteProgDone,
  input  logic              sectorEraseDone,
  input  logic              blockEraseDone,
  input  logic              chipEraseDone,
  input  logic              aaiTopReached,
  input  logic              wpN,
  input  logic              busyIn,
  input  logic              aaiIn,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        statusByte,
  output logic              writePermit,
  output logic              chipErasePermit
);
  localparam int QTR_MSB = ARRAY_AW - 1;

  statusStrobes_t strobes;
  logic           lockNow;
  logic [1:0]     quarter;
  logic           unusedAddrBits;

  assign quarter        = addr[QTR_MSB -: 2];
  assign unusedAddrBits = ^{addr[ADDR_W-1:ARRAY_AW], addr[ARRAY_AW-3:0]};

  flash_status_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .cmdWren         (cmdWren),
    .cmdWrdi         (cmdWrdi),
    .cmdEwsr         (cmdEwsr),
    .cmdWrsr         (cmdWrsr),
    .cmdOther        (cmdOther),
    .byteProgDone    (byteProgDone),
    .sectorEraseDone (sectorEraseDone),
    .blockEraseDone  (blockEraseDone),
    .chipEraseDone   (chipEraseDone),
    .aaiTopReached   (aaiTopReached),
    .wpN             (wpN),
    .lockNow         (lockNow),
    .strobes         (strobes)
  );

  flash_status_dp u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .wrData          (wrsrData),
    .busyIn          (busyIn),
    .aaiIn           (aaiIn),
    .quarter         (quarter),
    .statusByte      (statusByte),
    .lockNow         (lockNow),
    .writePermit     (writePermit),
    .chipErasePermit (chipErasePermit)
  );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWren,
  input logic       cmdWrdi,
  input logic       cmdEwsr,
  input logic       cmdWrsr,
  input logic       cmdOther,
  input logic       byteProgDone,
  input logic       sectorEraseDone,
  input logic       blockEraseDone,
  input logic       chipEraseDone,
  input logic       aaiTopReached,
  input logic       wpN,
  input logic [7:0] statusByte,
  input logic       writePermit,
  input logic       chipErasePermit
);
  logic doneAny;
  logic seenArm;

  assign doneAny = byteProgDone | sectorEraseDone | blockEraseDone |
                   chipEraseDone | aaiTopReached;

  always_ff @(posedge clk) begin
    if (!rstN)        seenArm <= 1'b0;
    else if (cmdEwsr) seenArm <= 1'b1;
    else if (cmdWren | cmdWrdi | cmdWrsr | cmdOther) seenArm <= 1'b0;
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[5:4] == 2'b00);

  assert_wel_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWren && !cmdWrdi && !doneAny) |=> statusByte[1]);

  assert_wel_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (doneAny || cmdWrdi) |=> !statusByte[1]);

  assert_unarmed_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !seenArm) |=> ($stable(statusByte[7]) && $stable(statusByte[3:2])));

  assert_locked_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !wpN && statusByte[7]) |=> ($stable(statusByte[7]) && $stable(statusByte[3:2])));

  assert_full_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] == 2'b11) |-> !writePermit);

  assert_permit_needs_wel_R8: assert property (@(posedge clk) disable iff (!rstN)
    writePermit |-> statusByte[1]);

  assert_chip_erase_R9: assert property (@(posedge clk) disable iff (!rstN)
    chipErasePermit |-> (statusByte[1] && statusByte[3:2] == 2'b00));
endmodule

bind flash_status_reg flash_status_chk u_chk (.*);

// File: tb/flash_status_reg_bench.sv
`timescale 1ns/1ps
module flash_status_reg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWren = 0, cmdWrdi = 0, cmdEwsr = 0, cmdWrsr = 0, cmdOther = 0;
  logic [7:0]  wrsrData = '0;
  logic        byteProgDone = 0, sectorEraseDone = 0, blockEraseDone = 0;
  logic        chipEraseDone = 0, aaiTopReached = 0;
  logic        wpN = 1'b1, busyIn = 1'b0, aaiIn = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  statusByte;
  logic        writePermit, chipErasePermit;

  int checks = 0;
  int errors = 0;

  // Bench model of the stored state.
  logic       mWel = 0, mLock = 0, mArm = 0;
  logic [1:0] mBp = 2'b11;

  always #5 clk = ~clk;

  flash_status_reg u_flash_status_reg (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus();
    return {mLock, aaiIn, 2'b00, mBp, mWel, busyIn};
  endfunction

  function automatic logic guardedExp(input logic [1:0] bp, input logic [1:0] q);
    return (bp == 2'b11) || (bp == 2'b10 && q[1]) || (bp == 2'b01 && q == 2'b11);
  endfunction

  // code: 0 wren 1 wrdi 2 arm 3 write 4 other 5..9 completion strobes
  task automatic issue(input int code, input logic [7:0] d, input string req);
    @(negedge clk);
    wrsrData = d;
    case (code)
      0: cmdWren = 1;  1: cmdWrdi = 1;  2: cmdEwsr = 1;  3: cmdWrsr = 1;
      4: cmdOther = 1; 5: byteProgDone = 1; 6: sectorEraseDone = 1;
      7: blockEraseDone = 1; 8: chipEraseDone = 1; default: aaiTopReached = 1;
    endcase
    if (code == 0) mWel = 1;
    if (code == 1 || code >= 5) mWel = 0;
    if (code == 3 && mArm && (wpN || !mLock)) begin
      mLock = d[7];
      mBp   = d[3:2];
    end
    if (code == 2) mArm = 1;
    else if (code <= 4) mArm = 0;
    @(negedge clk);
    {cmdWren, cmdWrdi, cmdEwsr, cmdWrsr, cmdOther} = '0;
    {byteProgDone, sectorEraseDone, blockEraseDone, chipEraseDone, aaiTopReached} = '0;
    check(req, statusByte, expStatus());
  endtask

  task automatic writeStatus(input logic [7:0] d, input string req);
    issue(2, 8'h00, req);
    issue(3, d, req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2", statusByte, 32'h0C);
    check("R2", writePermit, 0);
    check("R2", chipErasePermit, 0);

    // R1 mirrored flags and reserved bits
    for (int i = 0; i < 4; i++) begin
      busyIn = i[0]; aaiIn = i[1];
      #1;
      check("R1", statusByte, expStatus());
      check("R1", statusByte[5:4], 0);
    end
    busyIn = 0; aaiIn = 0;

    // R3 set and clear of the latch
    issue(0, 8'h00, "R3");
    check("R3", statusByte[1], 1);
    issue(1, 8'h00, "R3");
    check("R3", statusByte[1], 0);

    // R4 each completion clears the latch
    for (int k = 5; k <= 9; k++) begin
      issue(0, 8'h00, "R4");
      issue(k, 8'h00, "R4");
      check("R4", statusByte[1], 0);
    end
    // R4 completion wins over a same-cycle set
    @(negedge clk);
    cmdWren = 1; byteProgDone = 1;
    @(negedge clk);
    cmdWren = 0; byteProgDone = 0;
    check("R4", statusByte[1], 0);
    @(negedge clk);
    cmdWren = 1; cmdWrdi = 1;
    @(negedge clk);
    cmdWren = 0; cmdWrdi = 0;
    check("R4", statusByte[1], 0);

    // R5 arming rules
    issue(3, 8'h00, "R5");                 // not armed
    check("R5", statusByte[3:2], 2'b11);
    issue(2, 8'h00, "R5"); issue(4, 8'h00, "R5"); issue(3, 8'h00, "R5");
    check("R5", statusByte[3:2], 2'b11);
    issue(2, 8'h00, "R5"); issue(0, 8'h00, "R5"); issue(3, 8'h00, "R5");
    check("R5", statusByte[3:2], 2'b11);
    issue(2, 8'h00, "R5");
    repeat (3) @(negedge clk);             // idle keeps the arm
    issue(3, 8'h00, "R5");
    check("R5", statusByte[3:2], 2'b00);
    issue(3, 8'h8C, "R5");                 // arm consumed
    check("R5", statusByte, 32'h02);

    // R6 pin and lock sweep
    for (int w = 0; w < 2; w++) begin
      for (int l = 0; l < 2; l++) begin
        for (int p = 0; p < 5; p++) begin
          logic [7:0] pat;
          case (p)
            0: pat = 8'h00; 1: pat = 8'hFF; 2: pat = 8'h84;
            3: pat = 8'h08; default: pat = 8'h4B;
          endcase
          wpN = 1;
          writeStatus({l[0], 7'b0000100}, "R6");
          wpN = w[0];
          writeStatus(pat, "R6");
          check("R6", statusByte[3:2], (w == 1 || l == 0) ? pat[3:2] : 2'b01);
        end
      end
    end
    wpN = 1;
    issue(1, 8'h00, "R6");
    writeStatus(8'hFF, "R6");               // writes leave the latch alone
    check("R6", statusByte[1], 0);

    // R7 R8 R9 protection sweep
    for (int b = 0; b < 4; b++) begin
      writeStatus({4'b0000, b[1:0], 2'b00}, "R7");
      for (int e = 0; e < 2; e++) begin
        issue(e == 1 ? 0 : 1, 8'h00, "R8");
        for (int h = 0; h < 4; h++) begin
          for (int q = 0; q < 4; q++) begin
            addr = {6'(h * 21), q[1:0], 16'hA5A5 ^ 16'(q * 4097)};
            #1;
            check("R7", writePermit, e[0] & !guardedExp(b[1:0], q[1:0]));
            check("R9", chipErasePermit, e[0] & (b == 0));
          end
        end
      end
    end
    // R7 boundaries
    writeStatus(8'h04, "R7");
    issue(0, 8'h00, "R8");
    addr = 24'h02FFFF; #1; check("R7", writePermit, 1);
    addr = 24'h030000; #1; check("R7", writePermit, 0);
    writeStatus(8'h08, "R7");
    issue(0, 8'h00, "R8");
    addr = 24'h01FFFF; #1; check("R7", writePermit, 1);
    addr = 24'h020000; #1; check("R7", writePermit, 0);
    addr = 24'hFDFFFF; #1; check("R7", writePermit, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule